// File: doc/BRIEF.md
# Ultra DMA Burst Host Controller

This block runs the host end of a double-edge DMA burst on one disk channel. A DMA engine starts it with a direction and a word count. On a write, words come from a source FIFO and each one goes out on a level change of the host strobe, rising or falling. On a read, each level change of the device strobe captures one word, and that word is pushed into a sink FIFO. Both strobes are treated as ordinary signals in the core clock domain.

Either side can hold a burst. On writes, the device holds it by raising its ready line (active low), and the host then freezes its strobe. On reads, the host holds it by raising its own ready line (active low) when the sink FIFO runs short of room. The host also freezes its strobe when the source FIFO is empty. When the count is reached, the controller raises stop and waits for the device to release its line. It then drops the acknowledge and reports done together with the number of words moved.

Top module: `udma_burst_host`

## Requirements
- R1: While rst_n is low and on the first cycle after reset: dev_dmack_n=1, dev_stop=0, host_strb=1, busy=0, done=0, src_pop=0, snk_push=0, xfer_count=0.
- R2: start in idle latches dir_write (1=write to device), word_count and cycle_div. From the next cycle, dev_dmack_n is 0 through the burst and stop phases, and it returns to 1 only in the done cycle.
- R3: On a write, src_pop=1 in a cycle means that at the next edge bus_wdata takes src_data, host_strb inverts and xfer_count rises by one. The strobe starts high.
- R4: The write strobe never changes in a cycle where src_valid=0. src_pop stays 0 and host_strb keeps its level.
- R5: The write strobe never changes in a cycle where dev_strb=1 (device ready is active low, so 1 means pause).
- R6: Two write strobe changes are at least cycle_div cycles apart, with cycle_div=0 treated as 1. The first change of a burst may come in the first burst cycle.
- R7: On a read, every cycle in which dev_strb differs from its value in the previous cycle, before the count is reached, gives snk_push=1 in the next cycle with snk_data equal to bus_rdata from the edge cycle.
- R8: During a read burst, host_strb in the next cycle equals (snk_free < rd_margin). Strobe edges that arrive while paused are still captured. Outside an active read, host_strb is 1.
- R9: One cycle after xfer_count reaches word_count, dev_stop goes to 1 and stays there while dev_strb=0. The cycle after dev_strb=1 is seen is the done cycle (done=1, dev_dmack_n=1, dev_stop=0) for exactly one cycle, and idle follows.
- R10: xfer_count equals the number of words moved and never exceeds word_count. With word_count=0, no word moves.
- R11: start is ignored while busy=1, and the latched count and direction stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a burst (taken only when idle) |
| dir_write | input | 1 | 1 = write to device, 0 = read from device |
| word_count | input | CNT_W | Words to move in the burst |
| cycle_div | input | DIV_W | Minimum clocks between write strobe changes |
| rd_margin | input | FREE_W | Free-entry threshold for read pause |
| busy | output | 1 | Burst in progress (not idle) |
| done | output | 1 | One-cycle pulse when the burst has fully ended |
| xfer_count | output | CNT_W | Words moved in the current/last burst |
| src_valid | input | 1 | Source FIFO has a word |
| src_data | input | DW | Source FIFO head word |
| src_pop | output | 1 | Take the head word from the source FIFO |
| snk_free | input | FREE_W | Free entries in the sink FIFO |
| snk_push | output | 1 | Push snk_data into the sink FIFO |
| snk_data | output | DW | Captured read word |
| dev_dmack_n | output | 1 | DMA acknowledge, active low |
| dev_stop | output | 1 | Burst stop request to device |
| host_strb | output | 1 | Write strobe on writes, host ready (active low) on reads |
| dev_strb | input | 1 | Device read strobe on reads, device ready (active low) on writes |
| bus_wdata | output | DW | Data word driven to the device |
| bus_rdata | input | DW | Data word from the device |

## Verification
On a read, a device strobe edge can land in the same cycle that snk_free drops below rd_margin. That edge must still be captured even though the host raises its ready line on the next edge. The bench drives snk_free at random around the margin while the device toggles its strobe every cycle, so the capture and the pause often fall together. A per-cycle reference model judges every push, data word and ready level. On writes, source-empty gaps and device pauses overlap with the cycle_div spacing, and the bench checks the strobe level and src_pop in each of those cycles.

// File: rtl/udma_pkg.sv
// Shared types for the Ultra DMA burst host controller.
package udma_pkg;
    // Burst phases; order matters only for readability.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_STOP  = 2'd2,
        ST_FIN   = 2'd3
    } udma_state_e;
endpackage

// File: rtl/udma_ctrl.sv
// Burst sequencer: latches the request, counts words and walks through
// burst, stop and finish phases.
// Assumes word_step pulses only while the burst is active and unfinished.
module udma_ctrl
    import udma_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_write,
    input  logic [CNT_W-1:0] word_count,
    input  logic [DIV_W-1:0] cycle_div,
    input  logic             dev_strb,
    input  logic             word_step,
    output udma_state_e      state,
    output logic             dir_q,
    output logic [DIV_W-1:0] div_q,
    output logic [CNT_W-1:0] xfer_q,
    output logic             at_end
);
    logic [CNT_W-1:0] cnt_q;

    assign at_end = (xfer_q == cnt_q);

    // Phase register, request latch and word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            dir_q  <= 1'b0;
            cnt_q  <= '0;
            div_q  <= DIV_W'(1);
            xfer_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    dir_q  <= dir_write;
                    cnt_q  <= word_count;
                    div_q  <= (cycle_div == '0) ? DIV_W'(1) : cycle_div;
                    xfer_q <= '0;
                    state  <= ST_BURST;
                end
                ST_BURST: begin
                    if (at_end)
                        state <= ST_STOP;
                    else if (word_step)
                        xfer_q <= xfer_q + CNT_W'(1);
                end
                ST_STOP: if (dev_strb) state <= ST_FIN;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // The word counter never overruns the programmed count.
    p_xfer_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (xfer_q <= cnt_q));

    // A start while busy leaves the latched request untouched.
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> ($stable(cnt_q) && $stable(dir_q)));
endmodule

// File: rtl/udma_wr_strobe.sv
// Write path: paces the host strobe, takes one source word per strobe level
// change and holds the strobe when the source is empty or the device pauses.
// Assumes div_q >= 1; active is high only in an unfinished write burst.
module udma_wr_strobe #(
    parameter int DW    = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             active,
    input  logic [DIV_W-1:0] div_q,
    input  logic             src_valid,
    input  logic [DW-1:0]    src_data,
    input  logic             dev_rdy_n,
    output logic             src_pop,
    output logic             wr_strb,
    output logic [DW-1:0]    wdata
);
    logic [DIV_W-1:0] pace_q;
    logic [DIV_W:0]   gap_q;

    assign src_pop = active && src_valid && !dev_rdy_n && (pace_q == '0);

    // Strobe level, outgoing word and spacing counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pace_q  <= '0;
            wr_strb <= 1'b1;
            wdata   <= '0;
        end else if (idle) begin
            pace_q  <= '0;
            wr_strb <= 1'b1;
        end else if (src_pop) begin
            wr_strb <= ~wr_strb;
            wdata   <= src_data;
            pace_q  <= div_q - DIV_W'(1);
        end else if (active && pace_q != '0) begin
            pace_q  <= pace_q - DIV_W'(1);
        end
    end

    // Checker-side count of clocks since the last strobe change.
    always_ff @(posedge clk) begin
        if (!rst_n || idle)
            gap_q <= '1;
        else if (src_pop)
            gap_q <= (DIV_W+1)'(1);
        else if (gap_q != '1)
            gap_q <= gap_q + (DIV_W+1)'(1);
    end

    p_edge_needs_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && wr_strb != $past(wr_strb)) |-> $past(src_valid));

    p_edge_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && wr_strb != $past(wr_strb)) |-> !$past(dev_rdy_n));

    p_edge_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> (gap_q >= {1'b0, div_q}));
endmodule

// File: rtl/udma_rd_capture.sv
// Read path: captures one word on every device strobe level change and
// drives the host ready line high when the sink runs short of room.
// Assumes the device strobe is already in the core clock domain.
module udma_rd_capture #(
    parameter int DW     = 16,
    parameter int FREE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              dev_strb,
    input  logic [DW-1:0]     bus_rdata,
    input  logic [FREE_W-1:0] snk_free,
    input  logic [FREE_W-1:0] rd_margin,
    output logic              rd_step,
    output logic              snk_push,
    output logic [DW-1:0]     snk_data,
    output logic              rdy_n
);
    logic prev_q;

    assign rd_step = active && (dev_strb != prev_q);

    // Edge history, captured word, push strobe and pause level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= 1'b1;
            snk_push <= 1'b0;
            snk_data <= '0;
            rdy_n    <= 1'b1;
        end else begin
            prev_q   <= dev_strb;
            snk_push <= rd_step;
            if (rd_step) snk_data <= bus_rdata;
            rdy_n    <= active ? (snk_free < rd_margin) : 1'b1;
        end
    end

    p_push_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snk_push |-> ($past(dev_strb) != $past(dev_strb, 2)));

    p_pause_on_low_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && ($past(snk_free) < $past(rd_margin))) |-> rdy_n);
endmodule

// File: rtl/udma_burst_host.sv
// Top of the Ultra DMA burst host: joins the sequencer with the write and
// read paths and shapes the device-side acknowledge, stop and strobe.
// Assumes all device inputs are synchronous to clk.
module udma_burst_host
    import udma_pkg::*;
#(
    parameter int DW     = 16,
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 8,
    parameter int FREE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_write,
    input  logic [CNT_W-1:0]  word_count,
    input  logic [DIV_W-1:0]  cycle_div,
    input  logic [FREE_W-1:0] rd_margin,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  xfer_count,
    input  logic              src_valid,
    input  logic [DW-1:0]     src_data,
    output logic              src_pop,
    input  logic [FREE_W-1:0] snk_free,
    output logic              snk_push,
    output logic [DW-1:0]     snk_data,
    output logic              dev_dmack_n,
    output logic              dev_stop,
    output logic              host_strb,
    input  logic              dev_strb,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata
);
    udma_state_e      state;
    logic             dir_q, at_end, word_step, wr_strb, rdy_n, rd_step;
    logic             on_bus, act_wr, act_rd;
    logic [DIV_W-1:0] div_q;

    assign on_bus      = (state == ST_BURST) || (state == ST_STOP);
    assign act_wr      = (state == ST_BURST) && dir_q && !at_end;
    assign act_rd      = (state == ST_BURST) && !dir_q && !at_end;
    assign word_step   = dir_q ? src_pop : rd_step;
    assign busy        = (state != ST_IDLE);
    assign done        = (state == ST_FIN);
    assign dev_dmack_n = !on_bus;
    assign dev_stop    = (state == ST_STOP);
    assign host_strb   = on_bus ? (dir_q ? wr_strb : rdy_n) : 1'b1;

    udma_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
        .word_count(word_count), .cycle_div(cycle_div), .dev_strb(dev_strb),
        .word_step(word_step), .state(state), .dir_q(dir_q), .div_q(div_q),
        .xfer_q(xfer_count), .at_end(at_end)
    );

    udma_wr_strobe #(.DW(DW), .DIV_W(DIV_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .idle(state == ST_IDLE), .active(act_wr),
        .div_q(div_q), .src_valid(src_valid), .src_data(src_data),
        .dev_rdy_n(dev_strb), .src_pop(src_pop), .wr_strb(wr_strb),
        .wdata(bus_wdata)
    );

    udma_rd_capture #(.DW(DW), .FREE_W(FREE_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .active(act_rd), .dev_strb(dev_strb),
        .bus_rdata(bus_rdata), .snk_free(snk_free), .rd_margin(rd_margin),
        .rd_step(rd_step), .snk_push(snk_push), .snk_data(snk_data),
        .rdy_n(rdy_n)
    );

    p_stop_under_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_stop |-> !dev_dmack_n);

    p_stop_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_stop && !dev_strb) |=> dev_stop);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy && dev_dmack_n));

    p_ack_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> !dev_dmack_n);
endmodule

// File: tb/sim_udma_burst_host.sv
module sim_udma_burst_host;
    localparam int DW = 16, CNT_W = 16, DIV_W = 8, FREE_W = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, start = 1'b0, dir_write = 1'b0;
    logic [CNT_W-1:0] word_count = '0;
    logic [DIV_W-1:0] cycle_div = '0;
    logic [FREE_W-1:0] rd_margin = FREE_W'(4), snk_free = FREE_W'(20);
    logic src_valid = 1'b0, dev_strb = 1'b1;
    logic [DW-1:0] src_data = '0, bus_rdata = '0;
    logic busy, done, src_pop, snk_push, dev_dmack_n, dev_stop, host_strb;
    logic [CNT_W-1:0] xfer_count;
    logic [DW-1:0] snk_data, bus_wdata;

    udma_burst_host #(.DW(DW), .CNT_W(CNT_W), .DIV_W(DIV_W), .FREE_W(FREE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
        .word_count(word_count), .cycle_div(cycle_div), .rd_margin(rd_margin),
        .busy(busy), .done(done), .xfer_count(xfer_count), .src_valid(src_valid),
        .src_data(src_data), .src_pop(src_pop), .snk_free(snk_free),
        .snk_push(snk_push), .snk_data(snk_data), .dev_dmack_n(dev_dmack_n),
        .dev_stop(dev_stop), .host_strb(host_strb), .dev_strb(dev_strb),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int total = 0, bad = 0, cyc = 0;
    // Behavioural reference state.
    int m_state = 0, m_dir = 0, m_cnt = 0, m_div = 1, m_xfer = 0, m_pace = 0;
    int m_wstrb = 1, m_rdyn = 1, m_wdata = 0, m_sdata = 0, m_push = 0, m_prev = 1;
    int src_q[$];
    // Stimulus knobs.
    int dev_mode = 0, stall_pct = 0, gap_pct = 0, stop_cnt = 0, next_word = 16'h100;

    function automatic int m_pop();
        return (m_state == 1 && m_dir == 1 && m_xfer != m_cnt && src_valid === 1'b1
                && dev_strb === 1'b0 && m_pace == 0) ? 1 : 0;
    endfunction

    // Reference model: advances one step per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_dir = 0; m_cnt = 0; m_div = 1; m_xfer = 0; m_pace = 0;
            m_wstrb = 1; m_rdyn = 1; m_wdata = 0; m_sdata = 0; m_push = 0; m_prev = 1;
        end else begin
            int pop, edg;
            pop = m_pop();
            edg = (int'(dev_strb) != m_prev) ? 1 : 0;
            m_prev = int'(dev_strb);
            m_push = 0;
            case (m_state)
                0: begin
                    m_wstrb = 1; m_pace = 0; m_rdyn = 1;
                    if (start) begin
                        m_dir = int'(dir_write); m_cnt = int'(word_count);
                        m_div = (cycle_div == 0) ? 1 : int'(cycle_div);
                        m_xfer = 0; m_state = 1;
                    end
                end
                1: begin
                    if (m_xfer == m_cnt) begin
                        m_state = 2; m_rdyn = 1;
                    end else if (m_dir == 1) begin
                        m_rdyn = 1;
                        if (pop == 1) begin
                            m_wstrb = 1 - m_wstrb; m_wdata = int'(src_data);
                            m_xfer++; m_pace = m_div - 1;
                            void'(src_q.pop_front());
                        end else if (m_pace > 0) m_pace--;
                    end else begin
                        if (edg == 1) begin
                            m_push = 1; m_sdata = int'(bus_rdata); m_xfer++;
                        end
                        m_rdyn = (snk_free < rd_margin) ? 1 : 0;
                    end
                end
                2: begin
                    m_rdyn = 1;
                    if (dev_strb) m_state = 3;
                end
                default: begin m_rdyn = 1; m_state = 0; end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input int exp);
        total++;
        if (got !== 32'(exp)) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    // Per-cycle comparison of every output against the reference.
    task automatic compare();
        int on_bus;
        on_bus = (m_state == 1 || m_state == 2) ? 1 : 0;
        chk("R2 dmack_n", 32'(dev_dmack_n), 1 - on_bus);
        chk("R9 stop", 32'(dev_stop), (m_state == 2) ? 1 : 0);
        chk("R9 done", 32'(done), (m_state == 3) ? 1 : 0);
        chk("R11 busy", 32'(busy), (m_state != 0) ? 1 : 0);
        if (on_bus == 1 && m_dir == 1)
            chk("R3 R5 R6 write strobe", 32'(host_strb), m_wstrb);
        else
            chk("R8 host ready", 32'(host_strb), (on_bus == 1) ? m_rdyn : 1);
        chk("R4 src_pop", 32'(src_pop), m_pop());
        chk("R3 bus_wdata", 32'(bus_wdata), m_wdata);
        chk("R7 snk_push", 32'(snk_push), m_push);
        chk("R7 snk_data", 32'(snk_data), m_sdata);
        chk("R10 xfer_count", 32'(xfer_count), m_xfer);
    endtask

    // Drive the inputs for the next clock.
    task automatic drive();
        stop_cnt = dev_stop ? stop_cnt + 1 : 0;
        src_valid = (src_q.size() > 0) && ($urandom_range(99) >= gap_pct);
        src_data  = (src_q.size() > 0) ? DW'(src_q[0]) : '0;
        bus_rdata = DW'($urandom);
        snk_free  = FREE_W'($urandom_range(0, 9));
        if (dev_stop) dev_strb = (stop_cnt >= 2);
        else if (dev_mode == 1) dev_strb = ($urandom_range(99) < stall_pct);
        else if (dev_mode == 2) begin
            if ($urandom_range(99) >= gap_pct) dev_strb = ~dev_strb;
        end else dev_strb = 1'b1;
    endtask

    task automatic cycle(input logic st);
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (rst_n) compare();
        drive();
        start = st;
    endtask

    task automatic run(input int dir, input int cnt, input int div, input int mode,
                       input int stall, input int gap, input int poke_busy);
        int n;
        for (int i = 0; i < cnt + 4; i++) begin src_q.push_back(next_word); next_word++; end
        dev_mode = mode; stall_pct = stall; gap_pct = gap;
        dir_write = dir[0]; word_count = CNT_W'(cnt); cycle_div = DIV_W'(div);
        cycle(1'b1);
        cycle(1'b0);
        n = 0;
        while (m_state != 0 && n < 5000) begin
            // R11: a second start with other settings mid-burst.
            if (poke_busy == 1 && n == 2) begin
                word_count = CNT_W'(cnt + 50); dir_write = ~dir_write;
                cycle(1'b1);
                dir_write = dir[0]; word_count = CNT_W'(cnt);
            end else cycle(1'b0);
            n++;
        end
        if (n >= 5000) begin bad++; $display("FAIL R9 burst never ended"); end
        chk("R10 final count", 32'(xfer_count), cnt);
        chk("R9 back to idle dmack_n", 32'(dev_dmack_n), 1);
        dev_mode = 0;
        src_q.delete();
        repeat (2) cycle(1'b0);
    endtask

    initial begin
        repeat (4) cycle(1'b0);
        // R1: reset values, sampled while still in reset.
        chk("R1 dmack_n", 32'(dev_dmack_n), 1);
        chk("R1 stop", 32'(dev_stop), 0);
        chk("R1 host_strb", 32'(host_strb), 1);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 src_pop", 32'(src_pop), 0);
        chk("R1 snk_push", 32'(snk_push), 0);
        chk("R1 xfer_count", 32'(xfer_count), 0);
        rst_n = 1'b1;
        cycle(1'b0);
        chk("R1 idle after reset", 32'(busy), 0);
        run(1, 8, 1, 1, 0, 0, 0);     // R3: full-speed write
        run(1, 11, 3, 1, 30, 30, 1);  // R4 R5 R6 R11: paced write with stalls
        run(1, 5, 0, 1, 20, 0, 0);    // R6: cycle_div 0 acts as 1
        run(0, 13, 1, 2, 0, 40, 0);   // R7 R8: gapped read strobes
        run(0, 20, 1, 2, 0, 0, 1);    // R7 R8 R11: edge every cycle with pauses
        run(1, 0, 2, 1, 0, 0, 0);     // R10: empty write burst
        run(0, 0, 1, 2, 0, 0, 0);     // R10: empty read burst
        run(1, 30, 2, 1, 50, 50, 0);  // R4 R5: heavy stalls
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule